// File: doc/BRIEF.md
# DMA Control Register with Drain and Reset Interlocks

This block is the 16-bit control register at the head of a DMA controller. A simple register bus writes it: a one-cycle write strobe with write data, a read data bus that always shows the current register value, and a write acknowledge with an error flag. The register holds four priority-level request enables, a CRC engine enable, a DMA module enable and a software reset. Its outputs drive the rest of the controller: a level mask for the arbiter, the effective CRC and DMA enables, an abort request to the transfer logic, and a reset pulse for the controller's other registers.

Turning an engine off is not immediate. A CRC disable waits until the CRC engine reports that it is no longer busy. A DMA disable waits until the current burst has finished and the transfer buffer has drained, and it asks the transfer logic to abort while it waits. The software reset is accepted only when both engines are already off. Otherwise it is refused and the bus access is flagged as an error.

Top module: `dma_ctl_reg`

## Requirements
- R1: After the synchronous reset, the read data, the level mask, both enables, the abort request, the register reset pulse, the acknowledge and the error are all 0.
- R2: Write data bits 11:8 set the level enables. Bit 8+k enables priority level k and drives level_mask[k] from the cycle after the write. The bits read back at the same positions.
- R3: Bit 2 is the CRC enable. A write of 1 sets it from the next cycle. A write of 0 while crc_busy is 1 leaves the bit reading 1 until the clock edge at which crc_busy is seen low; after that edge it reads 0.
- R4: Bit 1 is the DMA enable. A write of 0 while xfer_idle is 0 leaves the bit at 1 and raises abort_req until the edge at which xfer_idle is seen high; after that edge both read 0. If xfer_idle is 1 when the 0 is written, the bit clears at once and abort_req stays 0.
- R5: Writing 0 to bit 0 starts no reset. regs_reset stays 0 and bit 0 reads 0.
- R6: A write with bit 0 set, made while both enables read 0 before the write, is accepted. From the next cycle regs_reset and read bit 0 are 1 for exactly RST_CYCLES cycles (2 by default), and all enables and the level mask read 0. The other fields of that write are discarded.
- R7: A write with bit 0 set, made while either enable reads 1 before the write, starts no reset. It raises the error together with its acknowledge, and the other fields of that write still apply as in R2 to R4.
- R8: Writes that arrive while a reset is running are acknowledged without error and change nothing.
- R9: Write data bits 15:12 and 7:3 are ignored, and those bits always read 0.
- R10: Every write raises bus_ack for exactly the following cycle. bus_err is only ever high together with bus_ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Current register value |
| bus_ack | output | 1 | Write acknowledge, the cycle after a write |
| bus_err | output | 1 | Error response, aligned with bus_ack |
| crc_busy | input | 1 | CRC engine still processing |
| xfer_idle | input | 1 | Burst finished and transfer buffer empty |
| crc_on | output | 1 | Effective CRC enable |
| dma_on | output | 1 | Effective DMA enable |
| abort_req | output | 1 | Request to abort the transfer while a disable drains |
| level_mask | output | 4 | Per-priority-level request enables to the arbiter |
| regs_reset | output | 1 | Reset pulse to the other controller registers |

## Verification
The bench uses the default RST_CYCLES of 2. With this value the reset window is short enough for the bench to count it cycle by cycle: it checks that the window lasts exactly two cycles and that a write placed in the window's first cycle is dropped. Holding crc_busy high and xfer_idle low for several cycles after a disable write tests that each enable stays on through the drain and clears on the first edge at which its status input is released.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

    localparam int DATA_W     = 16;
    localparam int NUM_LEVELS = 4;
    localparam int LVL_LSB    = 8;
    localparam int CRC_BIT    = 2;
    localparam int DMA_BIT    = 1;
    localparam int SRST_BIT   = 0;

    typedef logic [DATA_W-1:0]     word_t;
    typedef logic [NUM_LEVELS-1:0] lvl_t;

    // Fields carried by one bus write
    typedef struct packed {
        lvl_t lvl;
        logic crc;
        logic dma;
        logic srst;
    } ctl_fields_t;

    function automatic ctl_fields_t unpack_word(input word_t w);
        ctl_fields_t f;
        f.lvl  = w[LVL_LSB +: NUM_LEVELS];
        f.crc  = w[CRC_BIT];
        f.dma  = w[DMA_BIT];
        f.srst = w[SRST_BIT];
        return f;
    endfunction

    function automatic word_t pack_word(input ctl_fields_t f);
        word_t w;
        w                         = '0;
        w[LVL_LSB +: NUM_LEVELS]  = f.lvl;
        w[CRC_BIT]                = f.crc;
        w[DMA_BIT]                = f.dma;
        w[SRST_BIT]               = f.srst;
        return w;
    endfunction

endpackage

// File: rtl/dma_ctl_drain_en.sv
// Enable bit whose clear waits for the engine to go idle
module dma_ctl_drain_en (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic set_on,
    input  logic set_off,
    input  logic idle,
    output logic en,
    output logic pend
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            en   <= 1'b0;
            pend <= 1'b0;
        end else if (set_on) begin
            en   <= 1'b1;
            pend <= 1'b0;
        end else if (set_off && en) begin
            if (idle) begin
                en   <= 1'b0;
                pend <= 1'b0;
            end else begin
                pend <= 1'b1;
            end
        end else if (pend && idle) begin
            en   <= 1'b0;
            pend <= 1'b0;
        end
    end

    AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        pend |-> en); // R4

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (en && !idle && !clr) |=> en); // R3

    AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (pend && idle && !set_on && !clr) |=> (!en && !pend)); // R4

endmodule

// File: rtl/dma_ctl_srst.sv
// Fixed-length reset window started by an accepted software reset
module dma_ctl_srst #(
    parameter int RST_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start && cnt == '0) begin
            cnt <= CNT_W'(RST_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(RST_CYCLES)); // R6

    AST_WINDOW_STEP: assert property (@(posedge clk) disable iff (rst)
        busy |=> (cnt == $past(cnt) - 1'b1)); // R6

endmodule

// File: rtl/dma_ctl_bus_resp.sv
// Registered write acknowledge and error response
module dma_ctl_bus_resp (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic refuse,
    output logic ack,
    output logic err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack <= 1'b0;
            err <= 1'b0;
        end else begin
            ack <= wr;
            err <= wr && refuse;
        end
    end

    AST_ACK_FOLLOWS_WR: assert property (@(posedge clk) disable iff (rst)
        wr |=> ack); // R10

endmodule

// File: rtl/dma_ctl_reg.sv
module dma_ctl_reg
    import dma_ctl_pkg::*;
#(
    parameter int RST_CYCLES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_ack,
    output logic                  bus_err,
    input  logic                  crc_busy,
    input  logic                  xfer_idle,
    output logic                  crc_on,
    output logic                  dma_on,
    output logic                  abort_req,
    output logic [NUM_LEVELS-1:0] level_mask,
    output logic                  regs_reset
);

    ctl_fields_t wf;
    ctl_fields_t rf;
    lvl_t        lvl_q;
    logic        crc_en, crc_pend, dma_en, dma_pend;
    logic        win_busy;
    logic        live_wr, srst_req, srst_ok, srst_refused, field_wr;

    assign wf = unpack_word(bus_wdata);

    // Write decode, judged against the enables in force before this write
    assign live_wr      = bus_wr && !win_busy;
    assign srst_req     = live_wr && wf.srst;
    assign srst_ok      = srst_req && !crc_en && !dma_en;
    assign srst_refused = srst_req && (crc_en || dma_en);
    assign field_wr     = live_wr && !srst_ok;

    generate
        for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_lvl
            always_ff @(posedge clk) begin
                if (rst || srst_ok) begin
                    lvl_q[k] <= 1'b0;
                end else if (field_wr) begin
                    lvl_q[k] <= wf.lvl[k];
                end
            end
        end
    endgenerate

    dma_ctl_drain_en u_crc_en (
        .clk     (clk),
        .rst     (rst),
        .clr     (srst_ok),
        .set_on  (field_wr && wf.crc),
        .set_off (field_wr && !wf.crc),
        .idle    (!crc_busy),
        .en      (crc_en),
        .pend    (crc_pend)
    );

    dma_ctl_drain_en u_dma_en (
        .clk     (clk),
        .rst     (rst),
        .clr     (srst_ok),
        .set_on  (field_wr && wf.dma),
        .set_off (field_wr && !wf.dma),
        .idle    (xfer_idle),
        .en      (dma_en),
        .pend    (dma_pend)
    );

    dma_ctl_srst #(
        .RST_CYCLES (RST_CYCLES)
    ) u_srst (
        .clk   (clk),
        .rst   (rst),
        .start (srst_ok),
        .busy  (win_busy)
    );

    dma_ctl_bus_resp u_resp (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr),
        .refuse (srst_refused),
        .ack    (bus_ack),
        .err    (bus_err)
    );

    always_comb begin
        rf.lvl  = lvl_q;
        rf.crc  = crc_en;
        rf.dma  = dma_en;
        rf.srst = win_busy;
    end

    assign bus_rdata  = pack_word(rf);
    assign crc_on     = crc_en;
    assign dma_on     = dma_en;
    assign abort_req  = dma_pend;
    assign level_mask = lvl_q;
    assign regs_reset = win_busy;

    AST_REFUSED_ERR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_wdata[SRST_BIT] && !regs_reset && (crc_on || dma_on))
        |=> (bus_err && !regs_reset)); // R7

    AST_ERR_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> bus_ack); // R10

    AST_WINDOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        regs_reset |-> (!crc_on && !dma_on && level_mask == '0)); // R6

    AST_ABORT_WITH_EN: assert property (@(posedge clk) disable iff (rst)
        abort_req |-> dma_on); // R4

    AST_WINDOW_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && regs_reset) |=> !bus_err); // R8

endmodule

// File: tb/dma_ctl_reg_tb.sv
module dma_ctl_reg_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_ack, bus_err;
    logic        crc_busy = 1'b0;
    logic        xfer_idle = 1'b1;
    logic        crc_on, dma_on, abort_req, regs_reset;
    logic [3:0]  level_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dma_ctl_reg u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .crc_busy   (crc_busy),
        .xfer_idle  (xfer_idle),
        .crc_on     (crc_on),
        .dma_on     (dma_on),
        .abort_req  (abort_req),
        .level_mask (level_mask),
        .regs_reset (regs_reset)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    // {wdata, crc_busy, xfer_idle, exp_rdata, exp_err, req}
    localparam int NV = 7;
    localparam logic [42:0] VEC [NV] = '{
        {16'h0F00, 1'b0, 1'b1, 16'h0F00, 1'b0, 8'd2},  // R2
        {16'h0506, 1'b0, 1'b1, 16'h0506, 1'b0, 8'd2},  // R2 R3 R4
        {16'h0507, 1'b0, 1'b1, 16'h0506, 1'b1, 8'd7},  // R7
        {16'h0501, 1'b0, 1'b1, 16'h0500, 1'b1, 8'd7},  // R7 pre-write enables
        {16'hF0F8, 1'b0, 1'b1, 16'h0000, 1'b0, 8'd9},  // R9
        {16'h0A00, 1'b0, 1'b1, 16'h0A00, 1'b0, 8'd2},  // R2
        {16'h0A00, 1'b0, 1'b1, 16'h0A00, 1'b0, 8'd5}   // R5
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", bus_rdata, 16'h0000);
        check("R1 outputs", {9'd0, crc_on, dma_on, abort_req, regs_reset, bus_ack, bus_err, 1'b0}, 16'h0);
        check("R1 level_mask", {12'd0, level_mask}, 16'h0);

        for (int i = 0; i < NV; i++) begin
            crc_busy  = VEC[i][26];
            xfer_idle = VEC[i][25];
            do_write(VEC[i][42:27]);
            check($sformatf("R%0d vec%0d rdata", VEC[i][7:0], i), bus_rdata, VEC[i][24:9]);
            check($sformatf("R%0d vec%0d err", VEC[i][7:0], i), {15'd0, bus_err}, {15'd0, VEC[i][8]});
            check($sformatf("R%0d vec%0d no reset", VEC[i][7:0], i), {15'd0, regs_reset}, 16'h0);
            check("R10 ack", {15'd0, bus_ack}, 16'h1);
        end
        check("R2 level_mask", {12'd0, level_mask}, 16'h000A);
        @(negedge clk);
        check("R10 ack one cycle", {15'd0, bus_ack}, 16'h0);

        // R3 deferred CRC disable
        do_write(16'h0004);
        check("R3 crc on", {15'd0, crc_on}, 16'h1);
        crc_busy = 1'b1;
        do_write(16'h0000);
        check("R3 held while busy", bus_rdata, 16'h0004);
        repeat (3) @(negedge clk);
        check("R3 still held", {15'd0, crc_on}, 16'h1);
        crc_busy = 1'b0;
        @(negedge clk);
        check("R3 drained", bus_rdata, 16'h0000);

        // R4 deferred DMA disable with abort
        do_write(16'h0002);
        check("R4 dma on", {15'd0, dma_on}, 16'h1);
        xfer_idle = 1'b0;
        do_write(16'h0000);
        check("R4 held, abort", {14'd0, dma_on, abort_req}, 16'h3);
        repeat (3) @(negedge clk);
        check("R4 still held", {14'd0, dma_on, abort_req}, 16'h3);
        xfer_idle = 1'b1;
        @(negedge clk);
        check("R4 drained", {14'd0, dma_on, abort_req}, 16'h0);
        do_write(16'h0002);
        do_write(16'h0000);
        check("R4 immediate clear", {14'd0, dma_on, abort_req}, 16'h0);

        // R6 accepted reset, exact window
        do_write(16'h0300);
        do_write(16'h0001);
        check("R6 window c1", bus_rdata, 16'h0001);
        check("R6 pulse c1 no err", {14'd0, regs_reset, bus_err}, 16'h2);
        @(negedge clk);
        check("R6 window c2", {15'd0, regs_reset}, 16'h1);
        @(negedge clk);
        check("R6 window over", bus_rdata, 16'h0000);

        // R6 combined write: reset wins over other fields
        do_write(16'h0F07);
        check("R6 combined pulse", {15'd0, regs_reset}, 16'h1);
        repeat (2) @(negedge clk);
        check("R6 combined fields discarded", bus_rdata, 16'h0000);

        // R8 write inside the window is ignored
        do_write(16'h0001);
        bus_wr = 1'b1;
        bus_wdata = 16'h0F06;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_wdata = '0;
        check("R8 ack no err", {14'd0, bus_ack, bus_err}, 16'h2);
        @(negedge clk);
        check("R8 ignored", bus_rdata, 16'h0000);

        // R5 writing zero to reset bit does nothing
        do_write(16'h0000);
        check("R5 no pulse", {15'd0, regs_reset}, 16'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule